// File: doc/BRIEF.md
# Shift-and-Store Serial-to-Parallel Register

The block takes a serial bit stream on a shift clock and spreads it across a chain of stages. A separate storage stage copies the chain while a strobe input is held high. The storage stage feeds a set of parallel outputs that can be released to high impedance, so the block can sit on a shared bus. Loading the chain and presenting the word are therefore separate steps: new data can be shifted in while the previous word stays on the outputs.

Two serial outputs carry the last stage so that instances can be chained. The first changes on the rising edge of the shift clock, for links whose clock edges are fast. The second presents the same bit on the following falling edge, for links whose edges are slow. Any number of instances can be chained by wiring one instance's serial output to the next one's serial input and sharing the shift clock.

The block has no reset. The register contents are undefined until the chain has been filled by shifting. The stage count is a parameter with a default of 8.

Top module: `shift_store_reg`

## Requirements
- R1: The chain has STAGES stages (default 8). Parallel output bit i is driven from storage bit i, and storage bit i holds chain stage i+1, so after STAGES shifts of a word sent most significant bit first, the parallel outputs equal that word.
- R2: On each rising edge of `sclk`, `ser_in` is captured into stage 1 (bit 0) and every stage k passes its value to stage k+1.
- R3: `ser_fast` carries the last stage and changes only on the rising edge of `sclk`.
- R4: `ser_slow` keeps its previous value through the high phase of `sclk` and takes the value of `ser_fast` on the following falling edge.
- R5: While `strobe` is high, the storage stage is transparent and follows the chain, including changes made by shift edges during the high period.
- R6: While `strobe` is low, the storage stage holds its value whatever is shifted into the chain.
- R7: With `oe` high, `par_q` drives the storage contents. With `oe` low, every bit of `par_q` is high impedance, so another source can drive the same bus lines.
- R8: Changing `oe` alters neither the chain nor the storage contents.
- R9: `ser_fast` and `ser_slow` are always driven and do not depend on `oe`.
- R10: When `ser_fast` of one instance feeds `ser_in` of a second instance on the same `sclk`, the pair behaves as one chain of twice the length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Shift clock; rising edge shifts, falling edge updates `ser_slow` |
| ser_in | input | 1 | Serial data into stage 1 |
| strobe | input | 1 | Level-sensitive transfer from the chain into storage |
| oe | input | 1 | High drives `par_q`, low releases it to high impedance |
| par_q | output | STAGES | Parallel outputs from the storage stage (three-state) |
| ser_fast | output | 1 | Last stage, rising-edge timed cascade output |
| ser_slow | output | 1 | Last stage retimed to the falling edge |

## Verification
The hardest conditions to reach are the ones that fall between clock edges. The slow cascade output must still hold its old bit after the rising edge and change only at the falling edge, and the storage stage must follow shift edges while the strobe is high but stop the moment the strobe drops. The bench therefore drives the shift clock itself rather than letting it run free. This lets it raise and lower the strobe while the clock is idle and sample both serial outputs inside each half period. For the release to high impedance, the bench puts its own driver on the parallel bus lines: a value it writes can only read back intact if the block has really let go of the lines.

// File: rtl/sps_pkg.sv
package sps_pkg;

    // Default depth of one shift-and-store section.
    localparam int unsigned SPS_DEF_STAGES = 8;

    // Drive state of the parallel output pads.
    typedef enum logic {
        PAD_RELEASED = 1'b0,
        PAD_DRIVEN   = 1'b1
    } pad_drive_e;

    // Index of the stage that feeds the last one; guarded for tiny chains.
    function automatic int unsigned feeder_index(input int unsigned stages);
        return (stages > 1) ? stages - 2 : 0;
    endfunction

endpackage

// File: rtl/sps_shift_chain.sv
module sps_shift_chain #(
    parameter int unsigned STAGES = sps_pkg::SPS_DEF_STAGES
) (
    input  logic              sclk,
    input  logic              ser_in,
    output wire [STAGES-1:0]  stages
);

    // One flop per stage; stage 1 is bit 0.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic bit_q;
        if (g == 0) begin : g_head
            always_ff @(posedge sclk) bit_q <= ser_in;
        end else begin : g_body
            always_ff @(posedge sclk) bit_q <= stages[g-1];
        end
        assign stages[g] = bit_q;
    end

    // Edge counter used only to hold assertions off until history exists.
    logic [1:0] warm_q = '0;
    always_ff @(posedge sclk) if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;

    // R2: head stage takes the serial input seen at the previous edge.
    assert_head_capture_R2: assert property (@(posedge sclk) disable iff (warm_q != 2'd3)
        stages[0] === $past(ser_in));

    if (STAGES > 1) begin : g_move_chk
        // R2: each stage takes its neighbour's previous value.
        assert_stage_move_R2: assert property (@(posedge sclk) disable iff (warm_q != 2'd3)
            stages[STAGES-1:1] === $past(stages[STAGES-2:0]));
    end

endmodule

// File: rtl/sps_hold_latch.sv
module sps_hold_latch #(
    parameter int unsigned STAGES = sps_pkg::SPS_DEF_STAGES
) (
    input  logic              strobe,
    input  logic [STAGES-1:0] d,
    output logic [STAGES-1:0] q
);

    // Transparent while strobe is high, holds while low.
    always_latch begin
        if (strobe) q <= d;
    end

endmodule

// File: rtl/sps_slow_tap.sv
module sps_slow_tap (
    input  logic sclk,
    input  logic fast_bit,
    output logic slow_bit
);

    always_ff @(negedge sclk) slow_bit <= fast_bit;

    logic [1:0] warm_q = '0;
    always_ff @(posedge sclk) if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;

    // R4: at a rising edge the slow copy has caught up with the fast bit
    // that was launched one edge earlier (values sampled before the edge).
    assert_slow_lag_R4: assert property (@(posedge sclk) disable iff (warm_q != 2'd3)
        slow_bit === fast_bit);

endmodule

// File: rtl/sps_bus_driver.sv
module sps_bus_driver #(
    parameter int unsigned STAGES = sps_pkg::SPS_DEF_STAGES
) (
    input  logic              oe,
    input  logic [STAGES-1:0] data,
    output wire  [STAGES-1:0] pads
);
    import sps_pkg::*;

    pad_drive_e drive;
    assign drive = pad_drive_e'(oe);

    assign pads = (drive == PAD_DRIVEN) ? data : {STAGES{1'bz}};

endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg #(
    parameter int unsigned STAGES = sps_pkg::SPS_DEF_STAGES
) (
    input  logic              sclk,
    input  logic              ser_in,
    input  logic              strobe,
    input  logic              oe,
    output wire  [STAGES-1:0] par_q,
    output logic              ser_fast,
    output logic              ser_slow
);
    import sps_pkg::*;

    localparam int unsigned FEED = feeder_index(STAGES);

    wire  [STAGES-1:0] chain;
    logic [STAGES-1:0] held;

    sps_shift_chain #(.STAGES(STAGES)) u_chain (
        .sclk   (sclk),
        .ser_in (ser_in),
        .stages (chain)
    );

    sps_hold_latch #(.STAGES(STAGES)) u_hold (
        .strobe (strobe),
        .d      (chain),
        .q      (held)
    );

    sps_bus_driver #(.STAGES(STAGES)) u_pads (
        .oe   (oe),
        .data (held),
        .pads (par_q)
    );

    assign ser_fast = chain[STAGES-1];

    sps_slow_tap u_tap (
        .sclk     (sclk),
        .fast_bit (ser_fast),
        .slow_bit (ser_slow)
    );

    logic [1:0] warm_q = '0;
    always_ff @(posedge sclk) if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;

    // R3: the fast cascade bit is what the feeding stage held one edge earlier.
    assert_fast_out_R3: assert property (@(posedge sclk) disable iff (warm_q != 2'd3)
        ser_fast === $past(chain[FEED]));

    // R5: a strobe held high across an edge leaves storage equal to the chain.
    assert_follow_R5: assert property (@(posedge sclk) disable iff (warm_q != 2'd3)
        strobe |-> (held === chain));

endmodule

// File: tb/shift_store_reg_test.sv
module shift_store_reg_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;

    typedef struct packed {
        logic [15:0] stim;
        logic [7:0]  exp_a;
        logic [7:0]  exp_b;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{16'hA53C, 8'h3C, 8'hA5},
        '{16'h0000, 8'h00, 8'h00},
        '{16'hFFFF, 8'hFF, 8'hFF},
        '{16'h8001, 8'h01, 8'h80},
        '{16'h5AC3, 8'hC3, 8'h5A},
        '{16'h1E96, 8'h96, 8'h1E}
    };

    logic sclk = 1'b0;
    logic ser_in = 1'b0;
    logic strobe = 1'b0;
    logic oe_a = 1'b1;
    logic oe_b = 1'b1;
    logic drv_en = 1'b0;
    logic [7:0] drv_val = 8'h00;

    wire [7:0] bus_a;
    wire [7:0] par_b;
    logic fast_a, slow_a, fast_b, slow_b;

    assign bus_a = drv_en ? drv_val : 8'bzzzzzzzz;

    shift_store_reg #(.STAGES(8)) uut (
        .sclk(sclk), .ser_in(ser_in), .strobe(strobe), .oe(oe_a),
        .par_q(bus_a), .ser_fast(fast_a), .ser_slow(slow_a)
    );

    shift_store_reg #(.STAGES(8)) uut_b (
        .sclk(sclk), .ser_in(fast_a), .strobe(strobe), .oe(oe_b),
        .par_q(par_b), .ser_fast(fast_b), .ser_slow(slow_b)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    logic [15:0] mdl = '0;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Starts and ends just after a falling edge with sclk low.
    task automatic shift_bit(input logic b, input bit chk);
        logic old_fast_a, old_fast_b;
        old_fast_a = mdl[7];
        old_fast_b = mdl[15];
        ser_in = b;
        #(HALF) sclk = 1'b1;
        #1;
        mdl = {mdl[14:0], b};
        if (chk) begin
            check("R3 fast_a after rise", {15'd0, fast_a}, {15'd0, mdl[7]});
            check("R10 fast_b after rise", {15'd0, fast_b}, {15'd0, mdl[15]});
            check("R4 slow_a before fall", {15'd0, slow_a}, {15'd0, old_fast_a});
            check("R4 slow_b before fall", {15'd0, slow_b}, {15'd0, old_fast_b});
            if (strobe && oe_a && !drv_en)
                check("R5 storage follows during strobe", {8'd0, bus_a}, {8'd0, mdl[7:0]});
        end
        #(HALF - 1) sclk = 1'b0;
        #1;
        if (chk) begin
            check("R4 slow_a after fall", {15'd0, slow_a}, {15'd0, mdl[7]});
            check("R4 slow_b after fall", {15'd0, slow_b}, {15'd0, mdl[15]});
        end
    endtask

    task automatic shift_word(input logic [15:0] w, input int nbits, input bit chk);
        for (int i = nbits - 1; i >= 0; i--) shift_bit(w[i], chk);
    endtask

    task automatic pulse_strobe();
        strobe = 1'b1;
        #(HALF);
        strobe = 1'b0;
        #(HALF);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] frozen;
        #1;
        // No reset: fill both chains before any check.
        shift_word(16'h0F5A, 16, 1'b0);
        shift_bit(1'b0, 1'b0);
        shift_word(16'h0F5A, 16, 1'b1);
        pulse_strobe();
        check("R1 initial fill par_a", {8'd0, bus_a}, 16'h005A);
        check("R10 initial fill par_b", {8'd0, par_b}, 16'h000F);

        // Vector table: cascade of two sections, MSB first.
        for (int v = 0; v < NVEC; v++) begin
            shift_word(VECS[v].stim, 16, 1'b1);
            pulse_strobe();
            check("R1 R2 par_a from table", {8'd0, bus_a}, {8'd0, VECS[v].exp_a});
            check("R10 par_b from table", {8'd0, par_b}, {8'd0, VECS[v].exp_b});
        end

        // R6: strobe low, storage holds while new data shifts in.
        shift_word(16'h0077, 8, 1'b1);
        check("R6 par_a held", {8'd0, bus_a}, 16'h0096);
        check("R6 par_b held", {8'd0, par_b}, 16'h001E);

        // R5: transparent on raise, follows shift edges, freezes on fall.
        strobe = 1'b1;
        #1;
        check("R5 storage on strobe rise", {8'd0, bus_a}, {8'd0, mdl[7:0]});
        shift_word(16'h0005, 3, 1'b1);
        strobe = 1'b0;
        #1;
        frozen = mdl[7:0];
        shift_word(16'h0002, 2, 1'b1);
        check("R6 storage frozen after strobe fall", {8'd0, bus_a}, {8'd0, frozen});

        // R7: release to high impedance, bench drives the bus.
        oe_a = 1'b0;
        #1;
        drv_en = 1'b1;
        drv_val = 8'hC6;
        #1;
        check("R7 bus released (C6)", {8'd0, bus_a}, 16'h00C6);
        drv_val = 8'h39;
        #1;
        check("R7 bus released (39)", {8'd0, bus_a}, 16'h0039);

        // R8/R9: shifting and storing continue while outputs are released.
        shift_word(16'h00B4, 8, 1'b1);
        check("R9 fast_a with oe low", {15'd0, fast_a}, {15'd0, mdl[7]});
        check("R9 slow_a with oe low", {15'd0, slow_a}, {15'd0, mdl[7]});
        pulse_strobe();
        drv_en = 1'b0;
        #1;
        oe_a = 1'b1;
        #1;
        check("R7 R8 storage loaded while released", {8'd0, bus_a}, 16'h00B4);

        // R8: toggling oe leaves storage and chain untouched.
        for (int t = 0; t < 3; t++) begin
            oe_a = 1'b0;
            #2;
            oe_a = 1'b1;
            #2;
        end
        check("R8 storage after oe toggles", {8'd0, bus_a}, 16'h00B4);
        shift_bit(1'b1, 1'b1);
        check("R8 chain after oe toggles", {15'd0, fast_a}, {15'd0, mdl[7]});

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule